// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It holds the program counter and a 32-entry by 32-bit register file with two read ports and one write port. Each fetched word is decoded combinationally into a set of datapath select and enable signals, and the selected operation runs in the same cycle. The supported instructions are register-register add, subtract, AND, OR and signed set-less-than, word load, word store, branch-if-equal and unconditional jump.

Instruction memory and data memory live outside the core. The core presents the program counter as the instruction address and expects the instruction word back in the same cycle. For data, it presents an address, write data, a read enable and a write enable, and it expects read data back combinationally. A store is committed by the memory on the rising edge that ends the cycle.

Decoding happens in two levels. The 6-bit opcode gives a 2-bit ALU class (add, subtract, or use the function field). For register-register instructions, the 6-bit function field then picks the exact ALU operation.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge the PC becomes 0, so `imem_addr` reads 0; register contents written before the reset are still readable after it.
- R2: Opcode 0 with function field [5:0] equal to 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt (rs in [25:21], rt in [20:16]) into the register named by bits [15:11].
- R3: Opcode 0 with function 0x2A writes 1 into rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise.
- R4: Opcode 35 (load) drives `dmem_addr` with rs plus the sign-extended immediate [15:0] and writes `dmem_rdata` into rt; negative offsets are honoured.
- R5: Opcode 43 (store) drives `dmem_addr` with rs plus the sign-extended immediate, drives `dmem_wdata` with rt, and writes no register.
- R6: `dmem_rd_en` is high exactly when the current opcode is 35, and `dmem_wr_en` is high exactly when it is 43.
- R7: Opcode 4 with rs equal to rt sets the next PC to PC+4 plus the sign-extended immediate shifted left by 2, for both forward and backward offsets.
- R8: Opcode 4 with rs not equal to rt sets the next PC to PC+4.
- R9: Opcode 2 sets the next PC to {PC+4 bits [31:28], address field [25:0], 2'b00}.
- R10: Register 0 always reads as 0; writes that name it are discarded.
- R11: A register read in the same cycle that writes it returns the value held before that cycle.
- R12: Any opcode other than 0, 2, 4, 35 and 43 writes no register and no memory and advances the PC by 4.
- R13: Outside branches and jumps the PC advances by exactly 4 per cycle and stays word-aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Data to store |
| dmem_rdata | input | 32 | Data read at `dmem_addr`, same cycle |
| dmem_rd_en | output | 1 | Load in progress |
| dmem_wr_en | output | 1 | Store in progress, committed at the next rising edge |

## Verification
The bench sweeps every ALU operation over operand pairs that sit at the signed boundaries. A core that compared unsigned values in set-less-than, or that dropped a carry, stores the wrong word. It chains a register onto itself (`add r9,r9,r9`), so a register file that forwarded the new value into the same cycle would store eight times the seed instead of four. It also runs two unknown opcodes, a write to register 0, a load with a negative offset, and branches in both directions. These catch a decoder that writes by default, a register 0 that keeps data, unsigned immediates, and a branch offset without sign extension: each error shows up as a wrong or stray store, or as the PC missing the halt address. A final program after a second reset stores registers it never loaded, which exposes a reset that clears the register file.

// File: rtl/sc_pkg.sv
// Shared encodings and control bundle for the single-cycle core.
// Assumes the fixed 32-bit instruction layout: opcode [31:26], rs [25:21],
// rt [20:16], rd [15:11], function [5:0], immediate [15:0], target [25:0].
package sc_pkg;

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // Exact ALU operation codes.
    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_fn_e;

    // Coarse ALU class produced by the opcode decoder.
    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FIELD = 2'b10,
        CLS_RSVD  = 2'b11
    } alu_cls_e;

    typedef struct packed {
        logic     dst_is_rd;   // destination from rd, else rt
        logic     b_is_imm;    // second operand is the immediate
        logic     wb_from_mem; // write-back from data memory
        logic     reg_we;
        logic     mem_rd;
        logic     mem_wr;
        logic     is_branch;
        logic     is_jump;
        alu_cls_e alu_cls;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
// Opcode decoder: turns the 6-bit opcode into the datapath control bundle.
// Assumes unknown opcodes must leave all state except the PC untouched.
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    // Purpose: one control word per supported opcode; quiet default otherwise.
    always_comb begin
        ctrl = '0;
        ctrl.alu_cls = CLS_ADD;
        unique case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.alu_cls   = CLS_FIELD;
            end
            OPC_LOAD: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_we      = 1'b1;
                ctrl.mem_rd      = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_cls   = CLS_SUB;
            end
            OPC_JUMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: begin
                ctrl = '0;
                ctrl.alu_cls = CLS_ADD;
            end
        endcase
    end

endmodule

// File: rtl/sc_alu_ctrl.sv
// Second decode level: ALU class plus function field give the ALU operation.
// Assumes unlisted function codes fall back to addition.
module sc_alu_ctrl
    import sc_pkg::*;
(
    input  alu_cls_e   alu_cls,
    input  logic [5:0] funct,
    output alu_fn_e    alu_fn
);

    // Purpose: map class and function field onto one ALU operation code.
    always_comb begin
        alu_fn = ALU_ADD;
        case (alu_cls)
            CLS_ADD: alu_fn = ALU_ADD;
            CLS_SUB: alu_fn = ALU_SUB;
            CLS_FIELD: begin
                case (funct)
                    FN_ADD:  alu_fn = ALU_ADD;
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_ADD;
                endcase
            end
            default: alu_fn = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
// Combinational ALU with a zero flag. Set-less-than is a signed comparison.
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] result,
    output logic            zero
);

    // Purpose: compute the selected operation on both operands.
    always_comb begin
        unique case (fn)
            ALU_AND: result = a & b;
            ALU_OR:  result = a | b;
            ALU_ADD: result = a + b;
            ALU_SUB: result = a - b;
            ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_NOR: result = ~(a | b);
            default: result = a + b;
        endcase
    end

    assign zero = (result == '0);

endmodule

// File: rtl/sc_regfile.sv
// Register file: two combinational read ports, one write port on the rising
// edge. Entry 0 is hard-wired to zero. Not reset (contents survive rst_n);
// rst_n only gates the assertions.
module sc_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   raddr_a,
    input  logic [AW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata
);

    logic [XLEN-1:0] regs [NREGS];

    // Purpose: commit one write per cycle, never to entry 0.
    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Purpose: read ports see only stored state, so same-cycle writes are not visible.
    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

    // A port that keeps its address, and whose register was not written, keeps its value.
    AST_READ_HOLDS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (raddr_a == $past(raddr_a)) &&
         !($past(we) && ($past(waddr) == raddr_a))) |-> $stable(rdata_a)); // R11

    // A write to a non-zero entry is visible on the next cycle.
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr != '0) && (waddr == raddr_b)) |=>
        ((raddr_b != $past(raddr_b)) || (rdata_b == $past(wdata)))); // R11

endmodule

// File: rtl/sc_next_pc.sv
// Next-PC selection: sequential, taken branch or jump.
// Assumes XLEN is 32 so the jump target fills the word exactly.
module sc_next_pc #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] imm_ext,
    input  logic [25:0]     target,
    input  logic            is_branch,
    input  logic            alu_zero,
    input  logic            is_jump,
    output logic [XLEN-1:0] pc_next
);

    localparam int UPPER = XLEN - 28;

    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;

    assign pc_seq     = pc + XLEN'(4);
    assign br_target  = pc_seq + (imm_ext << 2);
    assign jmp_target = {pc_seq[XLEN-1 -: UPPER], target, 2'b00};

    // Purpose: jump wins, then a taken branch, else the next word.
    always_comb begin
        if (is_jump) begin
            pc_next = jmp_target;
        end else if (is_branch && alu_zero) begin
            pc_next = br_target;
        end else begin
            pc_next = pc_seq;
        end
    end

endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC, fetch, two-level decode, register file, ALU,
// write-back and next-PC selection. Assumes both memories answer
// combinationally and data memory commits stores on the rising edge.
module sc_core
    import sc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NREGS    = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            dmem_rd_en,
    output logic            dmem_wr_en
);

    localparam int AW = $clog2(NREGS);

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] pc_next;

    logic [5:0]      f_op;
    logic [AW-1:0]   f_rs;
    logic [AW-1:0]   f_rt;
    logic [AW-1:0]   f_rd;
    logic [5:0]      f_fn;
    logic [15:0]     f_imm;
    logic [25:0]     f_tgt;
    logic [4:0]      unused_shamt;

    ctrl_t           ctrl;
    alu_fn_e         alu_fn;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_res;
    logic            alu_zero;
    logic [AW-1:0]   wb_addr;
    logic [XLEN-1:0] wb_data;

    // Purpose: field split of the fetched word.
    assign f_op         = imem_rdata[31:26];
    assign f_rs         = imem_rdata[25:21];
    assign f_rt         = imem_rdata[20:16];
    assign f_rd         = imem_rdata[15:11];
    assign unused_shamt = imem_rdata[10:6];
    assign f_fn         = imem_rdata[5:0];
    assign f_imm        = imem_rdata[15:0];
    assign f_tgt        = imem_rdata[25:0];

    assign imm_ext = {{(XLEN-16){f_imm[15]}}, f_imm};

    sc_main_dec u_main_dec (
        .opcode (f_op),
        .ctrl   (ctrl)
    );

    sc_alu_ctrl u_alu_ctrl (
        .alu_cls (ctrl.alu_cls),
        .funct   (f_fn),
        .alu_fn  (alu_fn)
    );

    sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val),
        .we      (ctrl.reg_we),
        .waddr   (wb_addr),
        .wdata   (wb_data)
    );

    // Purpose: second operand source select.
    assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a      (rs_val),
        .b      (alu_b),
        .fn     (alu_fn),
        .result (alu_res),
        .zero   (alu_zero)
    );

    // Purpose: destination and write-back source selects.
    assign wb_addr = ctrl.dst_is_rd ? f_rd : f_rt;
    assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_res;

    // Purpose: data memory port.
    assign dmem_addr  = alu_res;
    assign dmem_wdata = rt_val;
    assign dmem_rd_en = ctrl.mem_rd;
    assign dmem_wr_en = ctrl.mem_wr;

    sc_next_pc #(.XLEN(XLEN)) u_next_pc (
        .pc        (pc),
        .imm_ext   (imm_ext),
        .target    (f_tgt),
        .is_branch (ctrl.is_branch),
        .alu_zero  (alu_zero),
        .is_jump   (ctrl.is_jump),
        .pc_next   (pc_next)
    );

    // Purpose: program counter with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else begin
            pc <= pc_next;
        end
    end

    assign imem_addr = pc;

    AST_PC_FROM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == RESET_PC)); // R1

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (pc[1:0] == 2'b00)); // R13

    AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_op != OPC_JUMP) && !((f_op == OPC_BEQ) && (rs_val == rt_val)))
        |=> (pc == $past(pc) + XLEN'(4))); // R13

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_op == OPC_BEQ) && (rs_val == rt_val))
        |=> (pc == $past(pc) + XLEN'(4) + ($past(imm_ext) << 2))); // R7

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (f_op == OPC_JUMP)
        |=> (pc[27:0] == {$past(f_tgt), 2'b00})); // R9

    AST_MEM_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd_en && dmem_wr_en)); // R6

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_op != OPC_REG) && (f_op != OPC_LOAD) && (f_op != OPC_STORE) &&
         (f_op != OPC_BEQ) && (f_op != OPC_JUMP))
        |-> (!ctrl.reg_we && !dmem_rd_en && !dmem_wr_en)); // R12

endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_rd_en, dmem_wr_en;

    always #2.5 clk = ~clk;

    sc_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_rd_en (dmem_rd_en),
        .dmem_wr_en (dmem_wr_en)
    );

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (rst_n && dmem_wr_en) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    int n_cmp = 0;
    int n_bad = 0;
    int wp = 0;
    logic mon_en = 1'b0;

    logic [31:0] ex_addr [32];
    logic [31:0] ex_data [32];
    string       ex_tag  [32];
    int          ex_cnt = 0;
    int          ex_idx = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(input int word_idx);
        return {6'd2, word_idx[25:0]};
    endfunction

    task automatic emit(input logic [31:0] w);
        imem[wp] = w;
        wp++;
    endtask

    task automatic want_store(input int addr, input logic [31:0] data, input string tag);
        ex_addr[ex_cnt] = addr;
        ex_data[ex_cnt] = data;
        ex_tag[ex_cnt]  = tag;
        ex_cnt++;
    endtask

    task automatic new_prog();
        for (int i = 0; i < 64; i++) imem[i] = 32'h0;
        wp = 0;
        ex_cnt = 0;
        ex_idx = 0;
    endtask

    // Per-cycle monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (mon_en) begin
            check(dmem_rd_en == (imem_rdata[31:26] == 6'd35), "R6 read enable",
                  {31'd0, dmem_rd_en}, {31'd0, imem_rdata[31:26] == 6'd35});
            check(dmem_wr_en == (imem_rdata[31:26] == 6'd43), "R6 write enable",
                  {31'd0, dmem_wr_en}, {31'd0, imem_rdata[31:26] == 6'd43});
            if (dmem_wr_en) begin
                if (ex_idx >= ex_cnt) begin
                    check(1'b0, "R5 unexpected store", dmem_addr, 32'hFFFFFFFF);
                end else begin
                    check(dmem_addr == ex_addr[ex_idx], {ex_tag[ex_idx], " store address"},
                          dmem_addr, ex_addr[ex_idx]);
                    check(dmem_wdata == ex_data[ex_idx], {ex_tag[ex_idx], " store data"},
                          dmem_wdata, ex_data[ex_idx]);
                    ex_idx++;
                end
            end
        end
    end

    task automatic run(input int cycles, input int halt_idx);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'h0, "R1 PC in reset", imem_addr, 32'h0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (cycles) @(negedge clk);
        mon_en = 1'b0;
        check(ex_idx == ex_cnt, "R5 store count", ex_idx, ex_cnt);
        check(imem_addr == 32'(halt_idx * 4), "R13 halt address", imem_addr, 32'(halt_idx * 4));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [31:0] pa [8];
    logic [31:0] pb [8];

    initial begin
        pa[0] = 32'd5;          pb[0] = 32'd3;
        pa[1] = 32'd3;          pb[1] = 32'd5;
        pa[2] = 32'hFFFFFFFF;   pb[2] = 32'd1;
        pa[3] = 32'd1;          pb[3] = 32'hFFFFFFFF;
        pa[4] = 32'h80000000;   pb[4] = 32'h7FFFFFFF;
        pa[5] = 32'h7FFFFFFF;   pb[5] = 32'h80000000;
        pa[6] = 32'hA5A5A5A5;   pb[6] = 32'hA5A5A5A5;
        pa[7] = 32'hF0F00FF0;   pb[7] = 32'h0FF0F00F;

        // ALU sweep: R2, R3, R4, R5.
        for (int p = 0; p < 8; p++) begin
            new_prog();
            for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
            dmem[0] = pa[p];
            dmem[1] = pb[p];
            emit(enc_i(6'd35, 0, 1, 0));
            emit(enc_i(6'd35, 0, 2, 4));
            emit(enc_r(1, 2, 3, 6'h20)); emit(enc_i(6'd43, 0, 3, 16));
            want_store(16, pa[p] + pb[p], "R2 add");
            emit(enc_r(1, 2, 4, 6'h22)); emit(enc_i(6'd43, 0, 4, 20));
            want_store(20, pa[p] - pb[p], "R2 sub");
            emit(enc_r(1, 2, 5, 6'h24)); emit(enc_i(6'd43, 0, 5, 24));
            want_store(24, pa[p] & pb[p], "R2 and");
            emit(enc_r(1, 2, 6, 6'h25)); emit(enc_i(6'd43, 0, 6, 28));
            want_store(28, pa[p] | pb[p], "R2 or");
            emit(enc_r(1, 2, 7, 6'h2A)); emit(enc_i(6'd43, 0, 7, 32));
            want_store(32, ($signed(pa[p]) < $signed(pb[p])) ? 32'd1 : 32'd0, "R3 slt a<b");
            emit(enc_r(2, 1, 8, 6'h2A)); emit(enc_i(6'd43, 0, 8, 36));
            want_store(36, ($signed(pb[p]) < $signed(pa[p])) ? 32'd1 : 32'd0, "R3 slt b<a");
            emit(enc_j(14));
            run(24, 14);
        end

        // Mixed program: R4, R7, R8, R9, R10, R11, R12.
        new_prog();
        for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
        dmem[0] = 32'h12345678;
        dmem[1] = 32'hCAFE0001;
        dmem[2] = 32'd12;
        emit(enc_i(6'd35, 0, 1, 0));
        emit(enc_i(6'd35, 0, 2, 4));
        emit(enc_i(6'd35, 0, 8, 8));
        emit(enc_i(6'd35, 8, 7, -4));                 // 3: r7 = mem[12-4]
        emit(enc_i(6'd43, 0, 7, 40));                 // 4
        want_store(40, 32'd12, "R4 negative offset load");
        emit(enc_r(1, 2, 0, 6'h20));                  // 5: write to r0
        emit(enc_i(6'd43, 0, 0, 44));                 // 6
        want_store(44, 32'd0, "R10 register zero");
        emit(enc_r(1, 1, 9, 6'h20));                  // 7
        emit(enc_r(9, 9, 9, 6'h20));                  // 8: read and write r9
        emit(enc_i(6'd43, 0, 9, 48));                 // 9
        want_store(48, 32'h12345678 * 4, "R11 old value read");
        emit(enc_i(6'd8, 0, 1, 5));                   // 10: unknown opcode
        emit(enc_i(6'h3F, 0, 2, 0));                  // 11: unknown opcode
        emit(enc_i(6'd43, 0, 1, 52));                 // 12
        want_store(52, 32'h12345678, "R12 unknown opcode r1");
        emit(enc_i(6'd43, 0, 2, 56));                 // 13
        want_store(56, 32'hCAFE0001, "R12 unknown opcode r2");
        emit(enc_i(6'd4, 1, 2, 1));                   // 14: not taken
        emit(enc_i(6'd43, 0, 2, 60));                 // 15
        want_store(60, 32'hCAFE0001, "R8 branch not taken");
        emit(enc_i(6'd4, 1, 1, 2));                   // 16: taken forward
        emit(enc_i(6'd43, 0, 1, 60));                 // 17: skipped
        emit(enc_i(6'd43, 0, 1, 60));                 // 18: skipped
        emit(enc_i(6'd43, 0, 2, 64));                 // 19
        want_store(64, 32'hCAFE0001, "R7 forward branch");
        emit(enc_j(40));                              // 20
        wp = 30;
        emit(enc_i(6'd43, 0, 7, 72));                 // 30
        emit(enc_j(50));                              // 31
        wp = 40;
        emit(enc_i(6'd43, 0, 8, 68));                 // 40
        want_store(68, 32'd12, "R9 jump target");
        want_store(72, 32'd12, "R7 backward branch");
        emit(enc_i(6'd4, 0, 0, 30 - 42));             // 41: back to 30
        wp = 50;
        emit(enc_j(50));                              // 50: halt
        run(40, 50);

        // Second reset keeps registers: R1.
        new_prog();
        emit(enc_i(6'd43, 0, 9, 128));
        want_store(128, 32'h12345678 * 4, "R1 registers survive reset r9");
        emit(enc_i(6'd43, 0, 7, 132));
        want_store(132, 32'd12, "R1 registers survive reset r7");
        emit(enc_j(2));
        run(8, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule